// File: doc/BRIEF.md
# Polled Byte-Write Controller for Slow Non-Volatile Memory

This block sits on the host side of a byte-wide non-volatile memory whose internal programming takes milliseconds. A client hands it one write request, made of an address and a byte, over a valid/ready handshake. The controller keeps a copy of both and drives one write strobe cycle at the memory. It then reads the same address back, again and again, until the programming has finished. While the memory is still programming, it returns the written byte with its top bit inverted. The controller therefore compares only that top bit of each readback with the copy it kept. When the two agree, it reports completion at once instead of waiting for the worst-case programming time. The typical programming time is about 6 ms and the worst case is 10 ms.

Between two readbacks the controller leaves the memory bus idle for a fixed number of cycles, so that the bus is free for other work. A run-time limit sets how many readbacks are allowed. When that many polls have all shown the programming still in progress, the controller raises a sticky error flag and returns to idle. Strobe timing is set in clock cycles by parameters: address setup, pulse width and hold.

Top module: `dpoll_writer`

## Requirements
- R1: After reset, reqReady is 1. memCeN, memWeN and memOeN are 1. memDataOe, doneOut and timeoutErr are 0.
- R2: A request is taken on a rising edge where reqValid and reqReady are both 1. reqReady then stays 0 until the cycle in which doneOut or a newly set timeoutErr is seen.
- R3: Each accepted request produces exactly one write access, at the request's address and with the request's byte. memCeN goes low SETUP_CYC cycles before memWeN falls. memWeN stays low for exactly PULSE_CYC cycles. memDataOe is 1 for every cycle in which memWeN is low.
- R4: Every readback is done at the stored address. memOeN is low for exactly PULSE_CYC cycles, memDataOe is 0 throughout, and memWeN and memOeN are never low in the same cycle.
- R5: Before each readback, including the first one after the write, memCeN is high for exactly YIELD_CYC consecutive cycles.
- R6: When bit 7 of a readback equals bit 7 of the stored byte, no further readback is made. doneOut is then 1 for exactly one cycle, in which reqReady is already 1.
- R7: When bit 7 of a readback differs from bit 7 of the stored byte, another readback follows, unless the poll limit has been reached.
- R8: The effective poll limit is cfgMaxPolls, where a value of 0 counts as 1. If that many readbacks have all mismatched, timeoutErr is set, no doneOut is given, and the controller returns to idle. A match on the last allowed poll counts as completion and not as an error.
- R9: timeoutErr stays 1 until the next request is accepted, and it is 0 from the cycle after that acceptance.
- R10: Only bit 7 takes part in the comparison. Bits 6 to 0 of the readback may differ from the stored byte without effect on completion.
- R11: Activity on reqValid, reqAddr and reqData while reqReady is 0 starts no further write and does not change the address used for readbacks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Write request valid |
| reqReady | output | 1 | Controller idle, can take a request |
| reqAddr | input | ADDR_W | Byte address to write |
| reqData | input | 8 | Byte to write |
| cfgMaxPolls | input | POLL_W | Maximum number of readbacks (0 counts as 1) |
| doneOut | output | 1 | One-cycle completion pulse |
| timeoutErr | output | 1 | Sticky poll-limit error |
| memAddr | output | ADDR_W | Memory address bus |
| memWrData | output | 8 | Memory write data |
| memDataOe | output | 1 | Host drives the memory data bus |
| memRdData | input | 8 | Memory read data |
| memCeN | output | 1 | Memory chip enable, active low |
| memWeN | output | 1 | Memory write strobe, active low |
| memOeN | output | 1 | Memory read strobe, active low |

## Verification
Two decisions can fall due at the same clock edge: the poll that succeeds and the poll limit running out. Both are made on the readback that uses up the final allowed poll. The bench's memory model keeps bit 7 inverted for a chosen number of readbacks. The bench sets that number to one less than the limit, so that the matching readback is exactly the last allowed one. It also sets it equal to the limit, so that the last allowed readback still mismatches. The first case must give doneOut with timeoutErr low. The second must give timeoutErr with no doneOut. In both cases the number of readbacks the model counted must equal the limit.

// File: rtl/dpoll_pkg.sv
package dpoll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_YIELD,
    ST_RSETUP,
    ST_RPULSE,
    ST_RHOLD
  } pollState_e;

  typedef enum logic [1:0] {
    PH_SETUP,
    PH_PULSE,
    PH_HOLD,
    PH_YIELD
  } phase_e;

  typedef struct packed {
    logic   loadReq;
    logic   cntClear;
    phase_e phaseSel;
    logic   sampleRd;
    logic   pollInc;
  } ctlStrobe_t;

endpackage

// File: rtl/dpoll_datapath.sv
module dpoll_datapath
  import dpoll_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int POLL_W    = 8,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 1,
  parameter int YIELD_CYC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] memRdData,
  input  logic [POLL_W-1:0] cfgMaxPolls,
  output logic [ADDR_W-1:0] latAddr,
  output logic [DATA_W-1:0] latData,
  output logic              phaseDone,
  output logic              bitMatch,
  output logic              pollLimit
);

  localparam int MAX_SP = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_HY = (HOLD_CYC > YIELD_CYC) ? HOLD_CYC : YIELD_CYC;
  localparam int PH_MAX = (MAX_SP > MAX_HY) ? MAX_SP : MAX_HY;
  localparam int CNT_W  = $clog2(PH_MAX + 1);
  localparam int MSB    = DATA_W - 1;

  logic [CNT_W-1:0]  phaseCnt;
  logic [POLL_W-1:0] pollCnt;
  logic              sampledBit;
  logic [POLL_W:0]   pollNumber;
  int                phaseLen;

  // Stored request: held from acceptance until the next acceptance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      latAddr <= '0;
      latData <= '0;
    end else if (ctl.loadReq) begin
      latAddr <= reqAddr;
      latData <= reqData;
    end
  end

  // Phase timer shared by setup, pulse, hold and yield intervals
  always_ff @(posedge clk) begin
    if (!rstN || ctl.cntClear) begin
      phaseCnt <= '0;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  always_comb begin
    case (ctl.phaseSel)
      PH_SETUP: phaseLen = SETUP_CYC;
      PH_PULSE: phaseLen = PULSE_CYC;
      PH_HOLD:  phaseLen = HOLD_CYC;
      default:  phaseLen = YIELD_CYC;
    endcase
  end

  assign phaseDone = (int'(phaseCnt) == phaseLen - 1);

  // Poll counter: number of completed mismatching readbacks
  always_ff @(posedge clk) begin
    if (!rstN || ctl.loadReq) begin
      pollCnt <= '0;
    end else if (ctl.pollInc) begin
      pollCnt <= pollCnt + 1'b1;
    end
  end

  assign pollNumber = {1'b0, pollCnt} + 1'b1;
  assign pollLimit  = (pollNumber >= {1'b0, cfgMaxPolls});

  // Readback capture: only the status bit is kept
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampledBit <= 1'b0;
    end else if (ctl.sampleRd) begin
      sampledBit <= memRdData[MSB];
    end
  end

  assign bitMatch = (sampledBit == latData[MSB]);

endmodule

// File: rtl/dpoll_ctrl.sv
module dpoll_ctrl
  import dpoll_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       phaseDone,
  input  logic       bitMatch,
  input  logic       pollLimit,
  output logic       reqReady,
  output logic       doneOut,
  output logic       timeoutErr,
  output ctlStrobe_t ctl,
  output logic       memCeN,
  output logic       memWeN,
  output logic       memOeN,
  output logic       memDataOe
);

  pollState_e state;
  pollState_e stateNext;
  logic       finishOk;
  logic       finishErr;

  always_comb begin
    stateNext    = state;
    ctl          = '0;
    ctl.phaseSel = PH_SETUP;
    finishOk     = 1'b0;
    finishErr    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.loadReq = 1'b1;
          stateNext   = ST_WSETUP;
        end
      end
      ST_WSETUP: begin
        ctl.phaseSel = PH_SETUP;
        if (phaseDone) stateNext = ST_WPULSE;
      end
      ST_WPULSE: begin
        ctl.phaseSel = PH_PULSE;
        if (phaseDone) stateNext = ST_WHOLD;
      end
      ST_WHOLD: begin
        ctl.phaseSel = PH_HOLD;
        if (phaseDone) stateNext = ST_YIELD;
      end
      ST_YIELD: begin
        ctl.phaseSel = PH_YIELD;
        if (phaseDone) stateNext = ST_RSETUP;
      end
      ST_RSETUP: begin
        ctl.phaseSel = PH_SETUP;
        if (phaseDone) stateNext = ST_RPULSE;
      end
      ST_RPULSE: begin
        ctl.phaseSel = PH_PULSE;
        if (phaseDone) begin
          ctl.sampleRd = 1'b1;
          stateNext    = ST_RHOLD;
        end
      end
      ST_RHOLD: begin
        ctl.phaseSel = PH_HOLD;
        if (phaseDone) begin
          if (bitMatch) begin
            finishOk  = 1'b1;
            stateNext = ST_IDLE;
          end else if (pollLimit) begin
            finishErr = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            ctl.pollInc = 1'b1;
            stateNext   = ST_YIELD;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    ctl.cntClear = (stateNext != state) || (state == ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      doneOut    <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      state   <= stateNext;
      doneOut <= finishOk;
      if (finishErr) begin
        timeoutErr <= 1'b1;
      end else if (ctl.loadReq) begin
        timeoutErr <= 1'b0;
      end
    end
  end

  assign reqReady  = (state == ST_IDLE);
  assign memCeN    = (state == ST_IDLE) || (state == ST_YIELD);
  assign memWeN    = (state != ST_WPULSE);
  assign memOeN    = (state != ST_RPULSE);
  assign memDataOe = (state == ST_WSETUP) || (state == ST_WPULSE) || (state == ST_WHOLD);

endmodule

// File: rtl/dpoll_writer.sv
module dpoll_writer
  import dpoll_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int POLL_W    = 8,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 1,
  parameter int YIELD_CYC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic [POLL_W-1:0] cfgMaxPolls,
  output logic              doneOut,
  output logic              timeoutErr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData,
  output logic              memDataOe,
  input  logic [7:0]        memRdData,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN
);

  ctlStrobe_t ctl;
  logic       phaseDone;
  logic       bitMatch;
  logic       pollLimit;

  dpoll_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .phaseDone  (phaseDone),
    .bitMatch   (bitMatch),
    .pollLimit  (pollLimit),
    .reqReady   (reqReady),
    .doneOut    (doneOut),
    .timeoutErr (timeoutErr),
    .ctl        (ctl),
    .memCeN     (memCeN),
    .memWeN     (memWeN),
    .memOeN     (memOeN),
    .memDataOe  (memDataOe)
  );

  dpoll_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (8),
    .POLL_W    (POLL_W),
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .YIELD_CYC (YIELD_CYC)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .reqAddr     (reqAddr),
    .reqData     (reqData),
    .memRdData   (memRdData),
    .cfgMaxPolls (cfgMaxPolls),
    .latAddr     (memAddr),
    .latData     (memWrData),
    .phaseDone   (phaseDone),
    .bitMatch    (bitMatch),
    .pollLimit   (pollLimit)
  );

endmodule

// File: rtl/dpoll_writer_chk.sv
module dpoll_writer_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              doneOut,
  input logic              timeoutErr,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memDataOe,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN
);

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  a_r11_addr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && $past(!reqReady)) |-> $stable(memAddr));

  a_r3_we_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memDataOe && !memCeN));

  a_r3_we_after_setup: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> $past(!memCeN));

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(!memWeN && !memOeN));

  a_r4_read_undriven: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (!memDataOe && !memCeN));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  a_r6_done_at_idle: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (reqReady && $past(!reqReady)));

  a_r8_err_at_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> (reqReady && !doneOut));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutErr && !(reqValid && reqReady)) |=> timeoutErr);

endmodule

bind dpoll_writer dpoll_writer_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .doneOut    (doneOut),
  .timeoutErr (timeoutErr),
  .memAddr    (memAddr),
  .memDataOe  (memDataOe),
  .memCeN     (memCeN),
  .memWeN     (memWeN),
  .memOeN     (memOeN)
);

// File: tb/dpoll_writer_tb.sv
module dpoll_writer_tb_top;

  localparam int ADDR_W    = 19;
  localparam int POLL_W    = 8;
  localparam int SETUP_CYC = 2;
  localparam int PULSE_CYC = 3;
  localparam int HOLD_CYC  = 1;
  localparam int YIELD_CYC = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [7:0]        reqData = '0;
  logic [POLL_W-1:0] cfgMaxPolls = '0;
  logic              doneOut;
  logic              timeoutErr;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0]        memWrData;
  logic              memDataOe;
  logic [7:0]        memRdData;
  logic              memCeN;
  logic              memWeN;
  logic              memOeN;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dpoll_writer #(
    .ADDR_W(ADDR_W), .POLL_W(POLL_W), .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC), .YIELD_CYC(YIELD_CYC)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqData(reqData), .cfgMaxPolls(cfgMaxPolls),
    .doneOut(doneOut), .timeoutErr(timeoutErr), .memAddr(memAddr),
    .memWrData(memWrData), .memDataOe(memDataOe), .memRdData(memRdData),
    .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model: bit 7 is inverted for busySet readbacks after each write
  int                busySet = 0;
  bit                scramble = 1'b0;
  logic [ADDR_W-1:0] expAddr = '0;
  logic [7:0]        expData = '0;
  logic [ADDR_W-1:0] mAddr = '0;
  logic [7:0]        mData = '0;
  bit                mValid = 1'b0;
  int                busyLeft = 0;
  int                writesTotal = 0;
  int                readsTotal = 0;
  int                weRun = 0;
  int                oeRun = 0;
  int                ceHighRun = 0;
  int                ceLowBeforeWe = 0;
  logic              prevWe = 1'b1;
  logic              prevOe = 1'b1;
  logic              prevCe = 1'b1;

  assign memRdData = (mValid && memAddr == mAddr)
                   ? ((busyLeft > 0 ? (mData ^ 8'h80) : mData) ^ (scramble ? 8'h55 : 8'h00))
                   : 8'h00;

  always @(negedge clk) begin
    if (rstN) begin
      if (!memWeN && !memOeN) check(1'b0, "R4 strobes overlap", 1, 0);
      if (!memWeN && !memDataOe) check(1'b0, "R3 data not driven in write", 0, 1);
      if (!memOeN && memDataOe) check(1'b0, "R4 data driven in read", 1, 0);
      if (!memCeN && prevCe) begin
        if (!memDataOe) check(ceHighRun == YIELD_CYC, "R5 yield gap", ceHighRun, YIELD_CYC);
        ceLowBeforeWe = 0;
      end
      if (memCeN) ceHighRun++; else ceHighRun = 0;
      if (!memCeN && memWeN && prevWe) ceLowBeforeWe++;
      if (!memWeN && prevWe) check(ceLowBeforeWe == SETUP_CYC, "R3 write setup", ceLowBeforeWe, SETUP_CYC);
      if (!memWeN) weRun++;
      if (memWeN && !prevWe) begin
        check(weRun == PULSE_CYC, "R3 write pulse width", weRun, PULSE_CYC);
        check(memAddr == expAddr, "R3 write address", memAddr, expAddr);
        check(memWrData == expData, "R3 write data", memWrData, expData);
        mAddr = memAddr;
        mData = memWrData;
        mValid = 1'b1;
        busyLeft = busySet;
        writesTotal++;
        weRun = 0;
      end
      if (!memOeN) oeRun++;
      if (memOeN && !prevOe) begin
        check(oeRun == PULSE_CYC, "R4 read pulse width", oeRun, PULSE_CYC);
        check(memAddr == expAddr, "R4 read address", memAddr, expAddr);
        readsTotal++;
        if (busyLeft > 0) busyLeft--;
        oeRun = 0;
      end
    end
    prevWe = memWeN;
    prevOe = memOeN;
    prevCe = memCeN;
  end

  always @(posedge clk) cycles++;

  task automatic runTxn(input logic [ADDR_W-1:0] a, input logic [7:0] d, input int busyN,
                        input int maxP, input bit holdValid, input bit scr);
    int w0, r0, effMax, expReads, waited;
    bit expDone, sawDone;
    cfgMaxPolls = POLL_W'(maxP);
    busySet = busyN;
    scramble = scr;
    while (!reqReady) @(negedge clk);
    w0 = writesTotal;
    r0 = readsTotal;
    expAddr = a;
    expData = d;
    reqValid = 1'b1;
    reqAddr = a;
    reqData = d;
    @(negedge clk);
    check(reqReady == 1'b0, "R2 ready low after accept", reqReady, 0);
    check(timeoutErr == 1'b0, "R9 error cleared on accept", timeoutErr, 0);
    if (holdValid) begin
      reqAddr = ~a;
      reqData = ~d;
    end else begin
      reqValid = 1'b0;
    end
    waited = 0;
    while (!doneOut && !(timeoutErr && reqReady) && waited < 20000) begin
      if (reqReady) check(1'b0, "R2 ready high while busy", reqReady, 0);
      @(negedge clk);
      waited++;
    end
    reqValid = 1'b0;
    check(waited < 20000, "R6 transaction finished", waited, 20000);
    effMax = (maxP == 0) ? 1 : maxP;
    expDone = (busyN + 1) <= effMax;
    expReads = expDone ? busyN + 1 : effMax;
    sawDone = doneOut;
    check(writesTotal - w0 == 1, "R11 one write per request", writesTotal - w0, 1);
    check(readsTotal - r0 == expReads, expDone ? "R6 readback count" : "R7 R8 readback count",
          readsTotal - r0, expReads);
    check(sawDone == expDone, "R6 done outcome", sawDone, expDone);
    check(timeoutErr == !expDone, "R8 timeout outcome", timeoutErr, !expDone);
    check(reqReady == 1'b1, "R2 ready back at finish", reqReady, 1);
    @(negedge clk);
    check(doneOut == 1'b0, "R6 done one cycle", doneOut, 0);
    check(timeoutErr == !expDone, "R9 error sticky", timeoutErr, !expDone);
    check(memCeN && memWeN && memOeN && !memDataOe, "R6 bus idle after finish",
          {memCeN, memWeN, memOeN, memDataOe}, 4'b1110);
    check(readsTotal - r0 == expReads, "R6 no extra readback", readsTotal - r0, expReads);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1 reset ready", reqReady, 1);
    check(memCeN && memWeN && memOeN, "R1 reset strobes", {memCeN, memWeN, memOeN}, 3'b111);
    check(!memDataOe && !doneOut && !timeoutErr, "R1 reset flags",
          {memDataOe, doneOut, timeoutErr}, 3'b000);

    // Directed corner cases
    runTxn(19'h05555, 8'hA5, 0, 4, 1'b0, 1'b0);   // R6 immediate match
    runTxn(19'h02AAA, 8'h3C, 2, 5, 1'b0, 1'b0);   // R7 mismatches then match
    runTxn(19'h7FFFF, 8'h80, 3, 4, 1'b0, 1'b0);   // R8 match on last allowed poll
    runTxn(19'h00000, 8'h01, 4, 4, 1'b0, 1'b0);   // R8 timeout
    runTxn(19'h12345, 8'hFF, 1, 3, 1'b1, 1'b0);   // R9 clear, R11 valid held while busy
    runTxn(19'h00777, 8'h6E, 0, 0, 1'b0, 1'b0);   // R8 limit 0 counts as 1, match
    runTxn(19'h00778, 8'h6E, 1, 0, 1'b0, 1'b0);   // R8 limit 0, timeout
    runTxn(19'h04321, 8'hC3, 1, 6, 1'b0, 1'b1);   // R10 low bits differ
    runTxn(19'h04322, 8'h00, 2, 3, 1'b1, 1'b1);   // R10 R11 combined

    // Constrained random
    for (int i = 0; i < 24; i++) begin
      runTxn(ADDR_W'($urandom), 8'($urandom), int'($urandom % 6), int'($urandom % 7),
             1'($urandom), 1'($urandom));
    end
    finished = 1'b1;
  end

  initial begin
    while (!finished && cycles < 150000) @(negedge clk);
    if (!finished) check(1'b0, "R6 watchdog expired", cycles, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule